// File: doc/BRIEF.md
# Virtual Wire Index Register Bank

This block is the device-side store for the sideband "virtual wire" channel of a host-attached serial link. It keeps two small banks of 4-bit wire groups. Incoming groups carry wires sent by the host. Outgoing groups carry wires that local logic sends back to the host. Each group carries an 8-bit index. Every access finds its group by matching that index, not by the group's position in the bank. The packet decoder writes incoming groups through a dedicated update port. Firmware-facing logic uses a one-request-per-cycle register port to read incoming groups, set and clear bits of outgoing groups, and rewrite the configuration of any group by slot number.

Each incoming bit carries its own valid flag, and a read returns only the bits that have been marked valid. Groups are cleared by the platform reset, the link reset or the cold reset, according to per-group enables. Three outgoing acknowledge wires follow their incoming warning wires without software help. Two of them follow one cycle later. The suspend acknowledge follows after a programmable delay of about 100 µs.

Top module: `vw_bank`

## Requirements
- R1: Register-port accesses and packet updates reach the enabled group whose index equals the request index, wherever that group sits in the bank; after slot 5 of the incoming bank is reprogrammed from index 47h to 55h, index 55h is served and 47h misses.
- R2: A read of an incoming group (op 0) returns the stored wire bits ANDed with the group's valid flags. A packet marks valid exactly the bits set in its valid nibble and writes only those bits, so a bit never marked valid reads 0.
- R3: Set (op 2) ORs the request mask into an outgoing group and clear (op 3) removes it. The other bits are kept. Bits outside the group's valid mask always stay 0. Outgoing slot s drives `out_wire_o[4s+3:4s]`.
- R4: An access to an index with no enabled match is ignored: a read returns 0 and no group changes. It also sets `miss_o`, which then stays set until `rst_ni`.
- R5: While `plt_rst_i` is high, every group whose platform-reset enable is set is cleared, including its valid flags. By default this is incoming 07h and 47h and outgoing 06h. Incoming 03h is kept.
- R6: While `bus_rst_i` is high, incoming groups with the link-reset enable are cleared (by default 03h, 07h, 41h, 47h). While `cold_rst_i` is high, outgoing groups with the cold-reset enable are cleared.
- R7: A packet that changes the valid-masked value of an incoming group raises `chg_o[slot]` for exactly one cycle, the cycle after the update edge, and only if that group's interrupt enable is set.
- R8: Outgoing 04h bit0 takes the valid-masked value of incoming 03h bit2 one cycle after that value changes. Outgoing 06h bit3 follows incoming 07h bit0 in the same way.
- R9: Outgoing 40h bit0 takes the value of incoming 41h bit0 `ACK_DLY`+1 cycles after the last change of that wire, and not before.
- R10: A configuration write (op 4 incoming, op 5 outgoing) replaces the group at `slot_i` with `cfg_i`: [7:0] index, [8] enable, [9] platform-reset enable, [10] link-reset enable (incoming) or cold-reset enable (outgoing), [11] interrupt enable (incoming), [15:12] valid mask (outgoing). A disabled group never matches.
- R11: After `rst_ni` every wire and valid flag is 0, `miss_o` and `chg_o` are 0, and the groups hold the default configuration: incoming 02h,03h,07h,41h,42h,47h in slots 0..5 with interrupts enabled, and outgoing 04h/0Dh, 05h/0Fh, 06h/0Ch, 40h/01h (index/valid mask) in slots 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset to defaults |
| plt_rst_i | input | 1 | Platform reset level |
| bus_rst_i | input | 1 | Link reset level |
| cold_rst_i | input | 1 | Cold reset level |
| req_i | input | 1 | Register-port request |
| op_i | input | 3 | 0 read in, 1 read out, 2 set, 3 clear, 4 config in, 5 config out |
| idx_i | input | 8 | Index for read/set/clear |
| mask_i | input | 4 | Bit mask for set/clear |
| slot_i | input | SLOT_W | Slot for configuration writes |
| cfg_i | input | 16 | Configuration word |
| rdata_o | output | 4 | Read data, same cycle as the request |
| miss_o | output | 1 | Sticky lookup-miss flag |
| pkt_vld_i | input | 1 | Packet update strobe |
| pkt_idx_i | input | 8 | Packet group index |
| pkt_wire_i | input | 4 | Packet wire values |
| pkt_vmask_i | input | 4 | Packet valid nibble |
| chg_o | output | NUM_IN | Per-slot change pulses |
| out_wire_o | output | 4*NUM_OUT | Outgoing wire groups by slot |

## Verification
A wrong lookup shows up at once. `rdata_o` is combinational, so a read hits the wrong group or returns a nonzero value on a miss in the same cycle. A wire or valid flag left set by a missed reset shows on the next read, and it also shows through the acknowledge wires one cycle later. A wrong change-detect register shows as a missing or extra `chg_o` pulse in the cycle right after the update. A delay counter that reloads or expires early shows as an acknowledge bit that moves before `ACK_DLY` cycles.

// File: rtl/vw_pkg.sv
package vw_pkg;

   localparam int IDXW = 8;
   localparam int WW   = 4;
   localparam int NUM_LINKS = 3;

   typedef enum logic [2:0] {
      OP_RD_IN  = 3'd0,
      OP_RD_OUT = 3'd1,
      OP_SET    = 3'd2,
      OP_CLR    = 3'd3,
      OP_CFG_IN = 3'd4,
      OP_CFG_OUT= 3'd5
   } op_e;

   typedef struct packed {
      logic [IDXW-1:0] idx;
      logic            en;
      logic            plt_en;
      logic            bus_en;
      logic            int_en;
   } in_cfg_t;

   typedef struct packed {
      logic [IDXW-1:0] idx;
      logic            en;
      logic            plt_en;
      logic            cold_en;
      logic [WW-1:0]   vmask;
   } out_cfg_t;

   typedef struct packed {
      logic [IDXW-1:0] src_idx;
      logic [1:0]      src_bit;
      logic [IDXW-1:0] dst_idx;
      logic [1:0]      dst_bit;
      logic            delayed;
   } link_t;

   function automatic in_cfg_t in_default(int i);
      case (i)
         0: return '{idx:8'h02, en:1'b1, plt_en:1'b0, bus_en:1'b0, int_en:1'b1};
         1: return '{idx:8'h03, en:1'b1, plt_en:1'b0, bus_en:1'b1, int_en:1'b1};
         2: return '{idx:8'h07, en:1'b1, plt_en:1'b1, bus_en:1'b1, int_en:1'b1};
         3: return '{idx:8'h41, en:1'b1, plt_en:1'b0, bus_en:1'b1, int_en:1'b1};
         4: return '{idx:8'h42, en:1'b1, plt_en:1'b0, bus_en:1'b0, int_en:1'b1};
         5: return '{idx:8'h47, en:1'b1, plt_en:1'b1, bus_en:1'b1, int_en:1'b1};
         default: return '0;
      endcase
   endfunction

   function automatic out_cfg_t out_default(int i);
      case (i)
         0: return '{idx:8'h04, en:1'b1, plt_en:1'b0, cold_en:1'b0, vmask:4'hD};
         1: return '{idx:8'h05, en:1'b1, plt_en:1'b0, cold_en:1'b0, vmask:4'hF};
         2: return '{idx:8'h06, en:1'b1, plt_en:1'b1, cold_en:1'b0, vmask:4'hC};
         3: return '{idx:8'h40, en:1'b1, plt_en:1'b0, cold_en:1'b0, vmask:4'h1};
         default: return '0;
      endcase
   endfunction

   function automatic link_t link_entry(int i);
      case (i)
         0: return '{src_idx:8'h03, src_bit:2'd2, dst_idx:8'h04, dst_bit:2'd0, delayed:1'b0};
         1: return '{src_idx:8'h07, src_bit:2'd0, dst_idx:8'h06, dst_bit:2'd3, delayed:1'b0};
         default: return '{src_idx:8'h41, src_bit:2'd0, dst_idx:8'h40, dst_bit:2'd0, delayed:1'b1};
      endcase
   endfunction

   function automatic in_cfg_t in_unpack(logic [15:0] w);
      return '{idx:w[7:0], en:w[8], plt_en:w[9], bus_en:w[10], int_en:w[11]};
   endfunction

   function automatic out_cfg_t out_unpack(logic [15:0] w);
      return '{idx:w[7:0], en:w[8], plt_en:w[9], cold_en:w[10], vmask:w[15:12]};
   endfunction

endpackage

// File: rtl/vw_lookup.sv
module vw_lookup #(
   parameter int N    = 4,
   parameter int IDXW = 8
) (
   input  logic [N-1:0][IDXW-1:0] idx_tab,
   input  logic [N-1:0]           en_tab,
   input  logic [IDXW-1:0]        key,
   output logic                   hit,
   output logic [N-1:0]           sel
);
   always_comb begin
      sel = '0;
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!hit && en_tab[i] && (idx_tab[i] == key)) begin
            sel[i] = 1'b1;
            hit    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vw_in_bank.sv
module vw_in_bank
   import vw_pkg::*;
#(
   parameter int N      = 6,
   parameter int SLOT_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   plt_rst_i,
   input  logic                   bus_rst_i,
   input  logic                   cfg_we_i,
   input  logic [SLOT_W-1:0]      cfg_slot_i,
   input  logic [15:0]            cfg_i,
   input  logic                   pkt_we_i,
   input  logic [N-1:0]           pkt_sel_i,
   input  logic [WW-1:0]          pkt_wire_i,
   input  logic [WW-1:0]          pkt_vmask_i,
   output in_cfg_t [N-1:0]        cfg_o,
   output logic [N-1:0][WW-1:0]   val_o,
   output logic [N-1:0]           chg_o
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      in_cfg_t       cfg_q;
      logic [WW-1:0] wire_q, vld_q, wire_n, vld_n;
      logic          chg_q, clr;

      assign clr    = (plt_rst_i && cfg_q.plt_en) || (bus_rst_i && cfg_q.bus_en);
      assign wire_n = (wire_q & ~pkt_vmask_i) | (pkt_wire_i & pkt_vmask_i);
      assign vld_n  = vld_q | pkt_vmask_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cfg_q  <= in_default(i);
            wire_q <= '0;
            vld_q  <= '0;
            chg_q  <= 1'b0;
         end else begin
            chg_q <= 1'b0;
            if (cfg_we_i && (cfg_slot_i == SLOT_W'(i)))
               cfg_q <= in_unpack(cfg_i);
            if (clr) begin
               wire_q <= '0;
               vld_q  <= '0;
            end else if (pkt_we_i && pkt_sel_i[i]) begin
               wire_q <= wire_n;
               vld_q  <= vld_n;
               chg_q  <= cfg_q.int_en && ((wire_n & vld_n) != (wire_q & vld_q));
            end
         end
      end

      assign cfg_o[i] = cfg_q;
      assign val_o[i] = wire_q & vld_q;
      assign chg_o[i] = chg_q;

      p_plt_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (plt_rst_i && cfg_q.plt_en) |=> (val_o[i] == '0));
      p_bus_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_rst_i && cfg_q.bus_en) |=> (val_o[i] == '0));
      p_chg_real_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         chg_q |-> (val_o[i] != $past(val_o[i])));
   end
endmodule

// File: rtl/vw_out_bank.sv
module vw_out_bank
   import vw_pkg::*;
#(
   parameter int N      = 4,
   parameter int NL     = 3,
   parameter int SLOT_W = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   plt_rst_i,
   input  logic                   cold_rst_i,
   input  logic                   cfg_we_i,
   input  logic [SLOT_W-1:0]      cfg_slot_i,
   input  logic [15:0]            cfg_i,
   input  logic                   bit_we_i,
   input  logic                   bit_set_i,
   input  logic [N-1:0]           bit_sel_i,
   input  logic [WW-1:0]          bit_mask_i,
   input  logic [NL-1:0]          lk_we_i,
   input  logic [NL-1:0][N-1:0]   lk_sel_i,
   input  logic [NL-1:0][1:0]     lk_bit_i,
   input  logic [NL-1:0]          lk_val_i,
   output out_cfg_t [N-1:0]       cfg_o,
   output logic [N-1:0][WW-1:0]   wire_o
);
   for (genvar i = 0; i < N; i++) begin : g_ent
      out_cfg_t      cfg_q, cfg_n;
      logic [WW-1:0] wire_q, wire_n;
      logic          clr;

      assign clr = (plt_rst_i && cfg_q.plt_en) || (cold_rst_i && cfg_q.cold_en);

      always_comb begin
         cfg_n = cfg_q;
         if (cfg_we_i && (cfg_slot_i == SLOT_W'(i)))
            cfg_n = out_unpack(cfg_i);
         wire_n = wire_q;
         if (bit_we_i && bit_sel_i[i])
            wire_n = bit_set_i ? (wire_n | bit_mask_i) : (wire_n & ~bit_mask_i);
         for (int l = 0; l < NL; l++) begin
            if (lk_we_i[l] && lk_sel_i[l][i])
               wire_n[lk_bit_i[l]] = lk_val_i[l];
         end
         wire_n = wire_n & cfg_n.vmask;
         if (clr)
            wire_n = '0;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cfg_q  <= out_default(i);
            wire_q <= '0;
         end else begin
            cfg_q  <= cfg_n;
            wire_q <= wire_n;
         end
      end

      assign cfg_o[i]  = cfg_q;
      assign wire_o[i] = wire_q;

      p_in_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wire_q & ~cfg_q.vmask) == '0);
      p_cold_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (cold_rst_i && cfg_q.cold_en) |=> (wire_q == '0));
   end
endmodule

// File: rtl/vw_ack_link.sv
module vw_ack_link #(
   parameter bit DELAYED = 1'b0,
   parameter int DLY     = 20000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   output logic we_o,
   output logic val_o
);
   localparam int CW = $clog2(DLY + 1);

   logic prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= src_i;
   end

   assign val_o = src_i;

   if (!DELAYED) begin : g_now
      assign we_o = (src_i != prev_q);
   end else begin : g_wait
      logic          pend_q;
      logic [CW-1:0] cnt_q;

      if (DLY < 1) begin : g_bad_dly
         $error("vw_ack_link: DLY must be at least 1");
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
         end else if (src_i != prev_q) begin
            pend_q <= 1'b1;
            cnt_q  <= CW'(DLY);
         end else if (pend_q) begin
            if (cnt_q == CW'(1)) pend_q <= 1'b0;
            else                 cnt_q  <= cnt_q - CW'(1);
         end
      end

      assign we_o = pend_q && (cnt_q == CW'(1)) && (src_i == prev_q);

      p_cnt_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pend_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(DLY)));
   end
endmodule

// File: rtl/vw_bank.sv
module vw_bank
   import vw_pkg::*;
#(
   parameter int NUM_IN  = 6,
   parameter int NUM_OUT = 4,
   parameter int SLOT_W  = 3,
   parameter int ACK_DLY = 20000
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    plt_rst_i,
   input  logic                    bus_rst_i,
   input  logic                    cold_rst_i,
   input  logic                    req_i,
   input  logic [2:0]              op_i,
   input  logic [7:0]              idx_i,
   input  logic [3:0]              mask_i,
   input  logic [SLOT_W-1:0]       slot_i,
   input  logic [15:0]             cfg_i,
   output logic [3:0]              rdata_o,
   output logic                    miss_o,
   input  logic                    pkt_vld_i,
   input  logic [7:0]              pkt_idx_i,
   input  logic [3:0]              pkt_wire_i,
   input  logic [3:0]              pkt_vmask_i,
   output logic [NUM_IN-1:0]       chg_o,
   output logic [4*NUM_OUT-1:0]    out_wire_o
);
   localparam int NL = NUM_LINKS;

   if (NUM_IN < 1 || NUM_OUT < 1 || ACK_DLY < 1 ||
       (2**SLOT_W) < NUM_IN || (2**SLOT_W) < NUM_OUT) begin : g_bad_cfg
      $error("vw_bank: illegal parameter set");
   end

   op_e op;
   assign op = op_e'(op_i);

   in_cfg_t  [NUM_IN-1:0]             in_cfg;
   out_cfg_t [NUM_OUT-1:0]            out_cfg;
   logic     [NUM_IN-1:0][WW-1:0]     in_val;
   logic     [NUM_OUT-1:0][WW-1:0]    out_val;
   logic     [NUM_IN-1:0][IDXW-1:0]   in_idx;
   logic     [NUM_OUT-1:0][IDXW-1:0]  out_idx;
   logic     [NUM_IN-1:0]             in_en;
   logic     [NUM_OUT-1:0]            out_en;

   always_comb begin
      for (int i = 0; i < NUM_IN; i++) begin
         in_idx[i] = in_cfg[i].idx;
         in_en[i]  = in_cfg[i].en;
      end
      for (int i = 0; i < NUM_OUT; i++) begin
         out_idx[i] = out_cfg[i].idx;
         out_en[i]  = out_cfg[i].en;
      end
   end

   // register-port and packet lookups
   logic                in_hit, out_hit, pkt_hit;
   logic [NUM_IN-1:0]   in_sel, pkt_sel;
   logic [NUM_OUT-1:0]  out_sel;

   vw_lookup #(.N(NUM_IN), .IDXW(IDXW)) u_lk_bus_in (
      .idx_tab(in_idx), .en_tab(in_en), .key(idx_i), .hit(in_hit), .sel(in_sel));
   vw_lookup #(.N(NUM_OUT), .IDXW(IDXW)) u_lk_bus_out (
      .idx_tab(out_idx), .en_tab(out_en), .key(idx_i), .hit(out_hit), .sel(out_sel));
   vw_lookup #(.N(NUM_IN), .IDXW(IDXW)) u_lk_pkt (
      .idx_tab(in_idx), .en_tab(in_en), .key(pkt_idx_i), .hit(pkt_hit), .sel(pkt_sel));

   // acknowledge links
   logic [NL-1:0]              lk_we, lk_val, lk_src;
   logic [NL-1:0][NUM_OUT-1:0] lk_sel;
   logic [NL-1:0][1:0]         lk_bit;

   for (genvar l = 0; l < NL; l++) begin : g_link
      localparam link_t LK = link_entry(l);
      logic               s_hit, d_hit;
      logic [NUM_IN-1:0]  s_sel;
      logic [NUM_OUT-1:0] d_sel;

      vw_lookup #(.N(NUM_IN), .IDXW(IDXW)) u_src (
         .idx_tab(in_idx), .en_tab(in_en), .key(LK.src_idx), .hit(s_hit), .sel(s_sel));
      vw_lookup #(.N(NUM_OUT), .IDXW(IDXW)) u_dst (
         .idx_tab(out_idx), .en_tab(out_en), .key(LK.dst_idx), .hit(d_hit), .sel(d_sel));

      always_comb begin
         lk_src[l] = 1'b0;
         for (int i = 0; i < NUM_IN; i++)
            if (s_sel[i]) lk_src[l] = in_val[i][LK.src_bit];
      end

      logic we_raw;
      vw_ack_link #(.DELAYED(LK.delayed), .DLY(ACK_DLY)) u_link (
         .clk_i(clk_i), .rst_ni(rst_ni), .src_i(lk_src[l] & s_hit),
         .we_o(we_raw), .val_o(lk_val[l]));

      assign lk_we[l]  = we_raw && d_hit;
      assign lk_sel[l] = d_sel;
      assign lk_bit[l] = LK.dst_bit;
   end

   vw_in_bank #(.N(NUM_IN), .SLOT_W(SLOT_W)) u_in (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .plt_rst_i(plt_rst_i), .bus_rst_i(bus_rst_i),
      .cfg_we_i(req_i && op == OP_CFG_IN), .cfg_slot_i(slot_i), .cfg_i(cfg_i),
      .pkt_we_i(pkt_vld_i && pkt_hit), .pkt_sel_i(pkt_sel),
      .pkt_wire_i(pkt_wire_i), .pkt_vmask_i(pkt_vmask_i),
      .cfg_o(in_cfg), .val_o(in_val), .chg_o(chg_o));

   vw_out_bank #(.N(NUM_OUT), .NL(NL), .SLOT_W(SLOT_W)) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .plt_rst_i(plt_rst_i), .cold_rst_i(cold_rst_i),
      .cfg_we_i(req_i && op == OP_CFG_OUT), .cfg_slot_i(slot_i), .cfg_i(cfg_i),
      .bit_we_i(req_i && (op == OP_SET || op == OP_CLR) && out_hit),
      .bit_set_i(op == OP_SET), .bit_sel_i(out_sel), .bit_mask_i(mask_i),
      .lk_we_i(lk_we), .lk_sel_i(lk_sel), .lk_bit_i(lk_bit), .lk_val_i(lk_val),
      .cfg_o(out_cfg), .wire_o(out_val));

   // read data and miss detection
   logic miss_now;

   always_comb begin
      rdata_o = '0;
      if (req_i && op == OP_RD_IN) begin
         for (int i = 0; i < NUM_IN; i++)
            if (in_sel[i]) rdata_o = rdata_o | in_val[i];
      end else if (req_i && op == OP_RD_OUT) begin
         for (int i = 0; i < NUM_OUT; i++)
            if (out_sel[i]) rdata_o = rdata_o | out_val[i];
      end
      miss_now = pkt_vld_i && !pkt_hit;
      if (req_i) begin
         case (op)
            OP_RD_IN:          miss_now = miss_now || !in_hit;
            OP_RD_OUT, OP_SET,
            OP_CLR:            miss_now = miss_now || !out_hit;
            OP_CFG_IN:         miss_now = miss_now || (int'(slot_i) >= NUM_IN);
            OP_CFG_OUT:        miss_now = miss_now || (int'(slot_i) >= NUM_OUT);
            default:           miss_now = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       miss_o <= 1'b0;
      else if (miss_now) miss_o <= 1'b1;
   end

   always_comb begin
      for (int i = 0; i < NUM_OUT; i++)
         out_wire_o[4*i +: 4] = out_val[i];
   end

   p_miss_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      miss_o |=> miss_o);
   p_miss_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && op == OP_RD_IN && !in_hit) |=> miss_o);
   p_miss_rd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && op == OP_RD_IN && !in_hit) |-> (rdata_o == '0));
endmodule

// File: tb/vw_bank_bench.sv
`timescale 1ns/1ps
module vw_bank_bench;
   localparam int NI = 6, NO = 4, SW = 3, DLY = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic plt = 0, bus = 0, cold = 0, req = 0, pv = 0;
   logic [2:0]  op = 0;
   logic [7:0]  idx = 0, pidx = 0;
   logic [3:0]  mask = 0, pw = 0, pm = 0, rdata;
   logic [SW-1:0] slot = 0;
   logic [15:0] cfg = 0;
   logic miss;
   logic [NI-1:0] chg;
   logic [4*NO-1:0] ow;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vw_bank #(.NUM_IN(NI), .NUM_OUT(NO), .SLOT_W(SW), .ACK_DLY(DLY)) u_vw_bank (
      .clk_i(clk), .rst_ni(rst_n), .plt_rst_i(plt), .bus_rst_i(bus), .cold_rst_i(cold),
      .req_i(req), .op_i(op), .idx_i(idx), .mask_i(mask), .slot_i(slot), .cfg_i(cfg),
      .rdata_o(rdata), .miss_o(miss), .pkt_vld_i(pv), .pkt_idx_i(pidx),
      .pkt_wire_i(pw), .pkt_vmask_i(pm), .chg_o(chg), .out_wire_o(ow));

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   function automatic logic [3:0] upd(logic [3:0] old, logic [3:0] nw, logic [3:0] m);
      return (old & ~m) | (nw & m);
   endfunction

   task automatic pkt(logic [7:0] i, logic [3:0] w, logic [3:0] m);
      pidx = i; pw = w; pm = m; pv = 1;
      @(negedge clk); pv = 0;
   endtask

   task automatic rd(logic [2:0] o, logic [7:0] i, output logic [3:0] d);
      req = 1; op = o; idx = i; #1 d = rdata;
      @(negedge clk); req = 0;
   endtask

   task automatic bitop(logic [2:0] o, logic [7:0] i, logic [3:0] m);
      req = 1; op = o; idx = i; mask = m;
      @(negedge clk); req = 0;
   endtask

   task automatic wcfg(logic [2:0] o, int s, logic [15:0] c);
      req = 1; op = o; slot = SW'(s); cfg = c;
      @(negedge clk); req = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [3:0] d, m02w, m02v, m05, prev;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 reset state
      chk("R11 out wires", ow, 0);
      chk("R11 miss", miss, 0);
      chk("R11 chg", chg, 0);
      rd(3'd0, 8'h47, d); chk("R11 read 47h", d, 0);
      chk("R11 no miss on default idx", miss, 0);

      // R2 / R7 directed
      pkt(8'h02, 4'b0111, 4'b0011);
      chk("R7 chg pulse", chg[0], 1);
      @(negedge clk);
      chk("R7 pulse one cycle", chg[0], 0);
      rd(3'd0, 8'h02, d); chk("R2 valid masking", d, 4'b0011);
      pkt(8'h02, 4'b0011, 4'b0011);
      chk("R7 no change no pulse", chg[0], 0);
      m02w = 4'b0011; m02v = 4'b0011; m05 = 0;

      // random phase: R2, R7, R3
      for (int k = 0; k < 200; k++) begin
         logic [3:0] rw, rm, bm;
         rw = 4'($urandom); rm = 4'($urandom); bm = 4'($urandom);
         prev = m02w & m02v;
         m02w = upd(m02w, rw, rm); m02v = m02v | rm;
         pkt(8'h02, rw, rm);
         chk("R7 random pulse", chg[0], ((m02w & m02v) != prev));
         rd(3'd0, 8'h02, d); chk("R2 random read", d, m02w & m02v);
         if ($urandom % 2) begin bitop(3'd2, 8'h05, bm); m05 = m05 | bm; end
         else begin bitop(3'd3, 8'h05, bm); m05 = m05 & ~bm; end
         chk("R3 random set/clr", ow[7:4], m05);
      end

      // R3 bits outside valid mask
      bitop(3'd2, 8'h04, 4'b0010);
      chk("R3 outside vmask stays 0", ow[3:0], 0);
      rd(3'd1, 8'h05, d); chk("R3 read out", d, m05);

      // R4 miss
      chk("R4 miss clear before", miss, 0);
      rd(3'd0, 8'h33, d); chk("R4 miss read zero", d, 0);
      chk("R4 miss sticky set", miss, 1);
      bitop(3'd2, 8'h33, 4'hF);
      chk("R4 miss write ignored", ow, {4'h0, 4'h0, m05, 4'h0});
      @(negedge clk); chk("R4 still sticky", miss, 1);

      // R7 interrupt disabled on slot 4 (42h)
      wcfg(3'd4, 4, 16'h0142);
      pkt(8'h42, 4'b0001, 4'b0001);
      chk("R7 int disabled no pulse", chg[4], 0);
      rd(3'd0, 8'h42, d); chk("R10 cfg keeps function", d, 4'b0001);

      // R8 immediate acks
      pkt(8'h03, 4'b0100, 4'b0100);
      chk("R8 ack not yet", ow[0], 0);
      @(negedge clk);
      chk("R8 oob ack follows", ow[0], 1);
      pkt(8'h07, 4'b0001, 4'b0001);
      @(negedge clk);
      chk("R8 host ack follows", ow[11], 1);

      // R9 delayed ack
      pkt(8'h41, 4'b0001, 4'b0001);
      repeat (20) @(negedge clk);
      chk("R9 suspend ack held off", ow[12], 0);
      repeat (25) @(negedge clk);
      chk("R9 suspend ack after delay", ow[12], 1);

      // R5 platform reset
      plt = 1; @(negedge clk); plt = 0;
      rd(3'd0, 8'h07, d); chk("R5 07h cleared", d, 0);
      rd(3'd0, 8'h03, d); chk("R5 03h kept", d, 4'b0100);
      rd(3'd0, 8'h02, d); chk("R5 02h kept", d, m02w & m02v);
      chk("R5 out 06h cleared", ow[11:8], 0);

      // R6 link reset and cold reset
      bus = 1; @(negedge clk); bus = 0;
      rd(3'd0, 8'h03, d); chk("R6 03h cleared", d, 0);
      rd(3'd0, 8'h02, d); chk("R6 02h kept", d, m02w & m02v);
      @(negedge clk);
      chk("R8 oob ack follows low", ow[0], 0);
      wcfg(3'd5, 1, 16'hF505);
      chk("R10 cfg out keeps wire", ow[7:4], m05);
      cold = 1; @(negedge clk); cold = 0;
      chk("R6 cold clears 05h", ow[7:4], 0);

      // R1 / R10 relocation and disable
      wcfg(3'd4, 5, 16'h0F55);
      pkt(8'h55, 4'b1010, 4'b1110);
      rd(3'd0, 8'h55, d); chk("R1 relocated index", d, 4'b1010);
      wcfg(3'd4, 4, 16'h0042);
      rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
      chk("R11 reset again", miss, 0);
      wcfg(3'd4, 5, 16'h0F55);
      rd(3'd0, 8'h47, d); chk("R1 old index misses", d, 0);
      chk("R1 miss on old index", miss, 1);
      wcfg(3'd4, 4, 16'h0042);
      rd(3'd0, 8'h42, d); chk("R10 disabled entry read 0", d, 0);

      finish_run();
   end
endmodule